// File: doc/BRIEF.md
# Retire-Stage Interrupt Controller

This block sits after the last stage of a five-stage in-order pipeline and decides, one retiring instruction at a time, whether to divert execution into an interrupt handler. It holds three coprocessor registers: an interrupt-control word (`STATUS`), a reason code (`CAUSE`) and a saved return address (`EPC`). Software reaches them through move-to and move-from accesses by register index. The block watches a single level-sensitive request line from the peripherals and answers on an acknowledge line.

An interrupt is taken only on a cycle in which a real instruction retires, so the return address is known exactly. When the retiring instruction changed control flow, the saved address is the PC it just wrote. Otherwise it is the instruction's own PC+4. On entry the block saves the enable bits by moving them up 16 places in `STATUS`, clears `CAUSE`, raises the acknowledge, sends the pipeline to a fixed handler address and flushes the younger instructions. A return-from-exception instruction does the reverse. The acknowledge is held until the peripheral has let go of its request, so the request/acknowledge pair always walks 00, 10, 11, 01, 00.

Top module: `irq_retire_ctl`

## Requirements
- R1: After reset, registers 12, 13 and 14 all read 0, `iack_o` is low, and `redirect_o` and `flush_o` are low.
- R2: A write with `cp_wr_i` high to index 12 (STATUS), 13 (CAUSE) or 14 (EPC) takes effect at the next clock edge. `cp_rdata_o` shows the register selected by `cp_idx_i` in the same cycle. Writes to any other index change nothing, and reads of any other index return 0.
- R3: An interrupt is entered only in a cycle with `ret_valid_i` high, a retire kind other than rfe, STATUS bit 1 set, `irq_i` high and `iack_o` low. Bubbles, a clear bit 1, or a high `iack_o` cause no redirect, no flush and no register change.
- R4: On entry, `redirect_o` and `flush_o` are high in the same cycle with `redirect_pc_o` = 0x00000004. From the next cycle `iack_o` is high, CAUSE reads 0 and STATUS reads the old STATUS shifted left 16 bits.
- R5: Retire kind encoding on `ret_kind_i` is 00 sequential, 01 jump, 10 conditional branch, 11 rfe. On entry, EPC receives `ret_newpc_i` for a jump or for a branch with `ret_taken_i` high. It receives `ret_pc4_i` for a sequential instruction or a branch that was not taken.
- R6: A valid retire of kind 11 (rfe) drives `redirect_o` and `flush_o` high in that cycle with `redirect_pc_o` equal to EPC. From the next cycle STATUS reads its old value logically shifted right 16 bits. No interrupt is entered in an rfe retire cycle.
- R7: At an rfe with `irq_i` low, `iack_o` falls at the next edge. With `irq_i` high, `iack_o` stays high and falls at the edge that ends the first later cycle in which `irq_i` is low.
- R8: A write (`cp_wr_i`) in the same cycle as an interrupt entry or an rfe is dropped, so the registers take only the event's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid_i | input | 1 | A real instruction retires this cycle |
| ret_kind_i | input | 2 | Retire kind: 00 seq, 01 jump, 10 branch, 11 rfe |
| ret_taken_i | input | 1 | Conditional branch outcome |
| ret_pc4_i | input | 32 | Retiring instruction's PC+4 |
| ret_newpc_i | input | 32 | PC just written by the retiring instruction |
| cp_wr_i | input | 1 | Move-to-coprocessor write strobe |
| cp_idx_i | input | 5 | Coprocessor register index for read and write |
| cp_wdata_i | input | 32 | Write data |
| cp_rdata_o | output | 32 | Read data for `cp_idx_i` |
| irq_i | input | 1 | Peripheral interrupt request |
| iack_o | output | 1 | Interrupt acknowledge |
| redirect_o | output | 1 | Load the PC from `redirect_pc_o` |
| redirect_pc_o | output | 32 | Redirect target |
| flush_o | output | 1 | Discard younger instructions |

## Verification
A wrong acknowledge state shows up at the ports within one cycle. An acknowledge stuck high blocks the next entry, which appears as a missing redirect on the next enabled retire. An acknowledge dropped early lets a second entry redirect while the first handler is still running. A corrupted STATUS or EPC stays hidden until it is read back or until the rfe redirect, where it shows as a wrong target or wrong restored mask. The bench therefore reads the registers back right after every entry and every return, and compares the handshake line on every cycle.

// File: rtl/irq_retire_pkg.sv
package irq_retire_pkg;

  typedef enum logic [1:0] {
    RK_SEQ    = 2'b00,
    RK_JUMP   = 2'b01,
    RK_BRANCH = 2'b10,
    RK_RFE    = 2'b11
  } ret_kind_e;

endpackage

// File: rtl/irq_ret_addr.sv
module irq_ret_addr
  import irq_retire_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  ret_kind_e        kind_i,
  input  logic             taken_i,
  input  logic [XLEN-1:0]  pc4_i,
  input  logic [XLEN-1:0]  newpc_i,
  output logic             use_newpc_o,
  output logic [XLEN-1:0]  ret_addr_o
);

  // Control transfer: resume where the instruction sent the PC.
  function automatic logic redirected(ret_kind_e k, logic tk);
    case (k)
      RK_JUMP:   return 1'b1;
      RK_RFE:    return 1'b1;
      RK_BRANCH: return tk;
      default:   return 1'b0;
    endcase
  endfunction

  assign use_newpc_o = redirected(kind_i, taken_i);
  assign ret_addr_o  = use_newpc_o ? newpc_i : pc4_i;

endmodule

// File: rtl/irq_hs.sv
module irq_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic rfe_i,
  input  logic irq_i,
  output logic iack_o,
  output logic rel_pend_o
);

  logic iack_q, pend_q;
  logic drop_now;

  assign drop_now = !irq_i && (rfe_i || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iack_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (take_i)        iack_q <= 1'b1;
      else if (drop_now) iack_q <= 1'b0;
      if (rfe_i && irq_i) pend_q <= 1'b1;
      else if (!irq_i)    pend_q <= 1'b0;
    end
  end

  assign iack_o     = iack_q;
  assign rel_pend_o = pend_q;

  // R7: the acknowledge never falls while the request was still high
  assert_iack_fall_after_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iack_q) |-> $past(!irq_i));

  // R3: the acknowledge only rises in answer to a request
  assert_iack_rise_needs_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_q) |-> $past(irq_i));

  // R7: a pending release completes as soon as the request is low
  assert_pending_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !irq_i && !take_i) |=> (!iack_q && !pend_q));

endmodule

// File: rtl/irq_cp0_regs.sv
module irq_cp0_regs #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned STATUS_IDX = 12,
  parameter int unsigned CAUSE_IDX  = 13,
  parameter int unsigned EPC_IDX    = 14,
  parameter int unsigned SAVE_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic             take_i,
  input  logic             rfe_i,
  input  logic [XLEN-1:0]  epc_next_i,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  rdata_o
);

  localparam logic [IDX_W-1:0] ST_I = IDX_W'(STATUS_IDX);
  localparam logic [IDX_W-1:0] CA_I = IDX_W'(CAUSE_IDX);
  localparam logic [IDX_W-1:0] EP_I = IDX_W'(EPC_IDX);

  logic [XLEN-1:0] status_q, cause_q, epc_q;
  logic            sw_wr;

  function automatic logic [XLEN-1:0] save_mask(logic [XLEN-1:0] s);
    return s << SAVE_SHIFT;
  endfunction

  function automatic logic [XLEN-1:0] restore_mask(logic [XLEN-1:0] s);
    return s >> SAVE_SHIFT;
  endfunction

  // R8: software writes yield to entry and return
  assign sw_wr = wr_i && !take_i && !rfe_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      cause_q  <= '0;
      epc_q    <= '0;
    end else if (take_i) begin
      status_q <= save_mask(status_q);
      cause_q  <= '0;
      epc_q    <= epc_next_i;
    end else if (rfe_i) begin
      status_q <= restore_mask(status_q);
    end else if (sw_wr) begin
      case (idx_i)
        ST_I:    status_q <= wdata_i;
        CA_I:    cause_q  <= wdata_i;
        EP_I:    epc_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      ST_I:    rdata_o = status_q;
      CA_I:    rdata_o = cause_q;
      EP_I:    rdata_o = epc_q;
      default: rdata_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign epc_o    = epc_q;

  // R4: entry saves the mask upward and clears the reason code
  assert_entry_regs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (cause_q == '0) && (status_q == ($past(status_q) << SAVE_SHIFT)));

  // R5: entry captures the chosen return address
  assert_entry_epc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (epc_q == $past(epc_next_i)));

  // R6: return restores the saved mask
  assert_rfe_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !take_i) |=> (status_q == ($past(status_q) >> SAVE_SHIFT)));

endmodule

// File: rtl/irq_retire_ctl.sv
module irq_retire_ctl
  import irq_retire_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned STATUS_IDX = 12,
  parameter int unsigned CAUSE_IDX  = 13,
  parameter int unsigned EPC_IDX    = 14,
  parameter int unsigned SAVE_SHIFT = 16,
  parameter int unsigned ENABLE_BIT = 1,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid_i,
  input  logic [1:0]       ret_kind_i,
  input  logic             ret_taken_i,
  input  logic [XLEN-1:0]  ret_pc4_i,
  input  logic [XLEN-1:0]  ret_newpc_i,
  input  logic             cp_wr_i,
  input  logic [IDX_W-1:0] cp_idx_i,
  input  logic [XLEN-1:0]  cp_wdata_i,
  output logic [XLEN-1:0]  cp_rdata_o,
  input  logic             irq_i,
  output logic             iack_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             flush_o
);

  ret_kind_e       kind;
  logic            take_w, rfe_w, use_newpc_w, pend_w;
  logic [XLEN-1:0] ret_addr_w, status_w, epc_w;

  assign kind = ret_kind_e'(ret_kind_i);

  // R3: entry only on a real retire, enabled, requested and not yet acknowledged
  assign take_w = ret_valid_i && (kind != RK_RFE) && status_w[ENABLE_BIT]
                  && irq_i && !iack_o;
  assign rfe_w  = ret_valid_i && (kind == RK_RFE);

  irq_ret_addr #(.XLEN(XLEN)) u_addr (
    .kind_i      (kind),
    .taken_i     (ret_taken_i),
    .pc4_i       (ret_pc4_i),
    .newpc_i     (ret_newpc_i),
    .use_newpc_o (use_newpc_w),
    .ret_addr_o  (ret_addr_w)
  );

  irq_hs u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take_w),
    .rfe_i      (rfe_w),
    .irq_i      (irq_i),
    .iack_o     (iack_o),
    .rel_pend_o (pend_w)
  );

  irq_cp0_regs #(
    .XLEN(XLEN), .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .CAUSE_IDX(CAUSE_IDX),
    .EPC_IDX(EPC_IDX), .SAVE_SHIFT(SAVE_SHIFT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (cp_wr_i),
    .idx_i      (cp_idx_i),
    .wdata_i    (cp_wdata_i),
    .take_i     (take_w),
    .rfe_i      (rfe_w),
    .epc_next_i (ret_addr_w),
    .status_o   (status_w),
    .epc_o      (epc_w),
    .rdata_o    (cp_rdata_o)
  );

  assign redirect_o    = take_w || rfe_w;
  assign flush_o       = redirect_o;
  assign redirect_pc_o = take_w ? HANDLER_PC : epc_w;

  // R4: an entry is acknowledged at the next edge
  assert_entry_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> $rose(iack_o));

  // R5: a sequential retire never saves the written PC
  assert_seq_uses_pc4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && kind == RK_SEQ) |-> !use_newpc_w);

  // R7: no release is pending while the acknowledge is low
  assert_pend_implies_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w |-> iack_o);

endmodule

// File: tb/irq_retire_ctl_tb_top.sv
module irq_retire_ctl_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        v = 1'b0, tk = 1'b0, wr = 1'b0, irq = 1'b0;
  logic [1:0]  k = 2'b00;
  logic [31:0] pc4 = '0, npc = '0, wd = '0;
  logic [4:0]  idx = '0;
  logic [31:0] rdata, rpc;
  logic        iack, redir, flush;

  irq_retire_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ret_valid_i(v), .ret_kind_i(k), .ret_taken_i(tk),
    .ret_pc4_i(pc4), .ret_newpc_i(npc), .cp_wr_i(wr), .cp_idx_i(idx),
    .cp_wdata_i(wd), .cp_rdata_o(rdata), .irq_i(irq), .iack_o(iack),
    .redirect_o(redir), .redirect_pc_o(rpc), .flush_o(flush)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  string rtag = "R2";

  // reference state
  logic [31:0] m_st = '0, m_ca = '0, m_epc = '0;
  bit m_iack = 1'b0, m_pend = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [4:0] i);
    if (i == 5'd12) return m_st;
    if (i == 5'd13) return m_ca;
    if (i == 5'd14) return m_epc;
    return 32'h0;
  endfunction

  // one cycle: compare at mid-cycle, then advance the model on the edge
  task automatic step();
    bit enter, ret, old_pend;
    logic [31:0] ra;
    string tg;
    #1;
    enter = v && (k != 2'b11) && m_st[1] && irq && !m_iack;
    ret   = v && (k == 2'b11);
    tg    = enter ? "R4" : (ret ? "R6" : "R3");
    chk(tg, "redirect", {31'b0, redir}, {31'b0, enter || ret});
    chk(tg, "flush", {31'b0, flush}, {31'b0, enter || ret});
    if (enter) chk("R4", "handler pc", rpc, 32'h4);
    if (ret)   chk("R6", "return pc", rpc, m_epc);
    chk(m_pend ? "R7" : "R3", "iack", {31'b0, iack}, {31'b0, m_iack});
    chk(rtag, "mfc0", rdata, m_read(idx));
    @(posedge clk);
    ra = ((k == 2'b01) || (k == 2'b10 && tk)) ? npc : pc4;
    old_pend = m_pend;
    if (enter) begin
      m_st = m_st << 16; m_ca = 0; m_epc = ra; m_iack = 1'b1;
    end else if (ret) begin
      m_st = m_st >> 16;
      if (!irq) m_iack = 1'b0; else m_pend = 1'b1;
    end else if (wr) begin
      if (idx == 5'd12) m_st = wd;
      else if (idx == 5'd13) m_ca = wd;
      else if (idx == 5'd14) m_epc = wd;
    end
    if (old_pend && !irq) begin m_iack = 1'b0; m_pend = 1'b0; end
    @(negedge clk);
  endtask

  task automatic go(logic vv, logic [1:0] kk, logic tt, logic [31:0] p4, logic [31:0] np,
                    logic ww, logic [4:0] ii, logic [31:0] dd, logic rq);
    v = vv; k = kk; tk = tt; pc4 = p4; npc = np; wr = ww; idx = ii; wd = dd; irq = rq;
    step();
    v = 1'b0; wr = 1'b0;
  endtask

  // explicit readback with an independently stated value
  task automatic rd(logic [4:0] ii, logic [31:0] exp, string tag);
    v = 1'b0; wr = 1'b0; idx = ii;
    #1 chk(tag, "readback", rdata, exp);
    rtag = tag;
    step();
    rtag = "R2";
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 chk("R1", "iack after reset", {31'b0, iack}, 32'h0);
    chk("R1", "redirect after reset", {31'b0, redir}, 32'h0);
    rd(5'd12, 32'h0, "R1"); rd(5'd13, 32'h0, "R1"); rd(5'd14, 32'h0, "R1");

    // R2 register access
    go(0, 0, 0, 0, 0, 1, 5'd5, 32'hffff_ffff, 0);
    rd(5'd5, 32'h0, "R2");
    go(0, 0, 0, 0, 0, 1, 5'd13, 32'hdead_beef, 0);
    rd(5'd13, 32'hdead_beef, "R2");
    go(0, 0, 0, 0, 0, 1, 5'd14, 32'h0000_0100, 0);
    rd(5'd14, 32'h0000_0100, "R2");

    // R3 masked: request ignored
    go(1, 2'b00, 0, 32'h1004, 32'h0, 0, 5'd0, 0, 1);
    rd(5'd14, 32'h0000_0100, "R3");
    go(0, 0, 0, 0, 0, 1, 5'd12, 32'h0000_00a3, 1);
    // R3 bubbles never enter
    go(0, 2'b00, 0, 32'h1008, 0, 0, 5'd0, 0, 1);
    go(0, 2'b01, 0, 32'h100c, 32'h5000, 0, 5'd0, 0, 1);
    rd(5'd14, 32'h0000_0100, "R3");

    // R4/R5 entry on sequential retire
    go(1, 2'b00, 0, 32'h2000, 32'h7777, 0, 5'd0, 0, 1);
    rd(5'd14, 32'h2000, "R5");
    rd(5'd12, 32'h00a3_0000, "R4");
    rd(5'd13, 32'h0, "R4");
    // R3 no re-entry while acknowledged
    go(1, 2'b00, 0, 32'h0008, 0, 0, 5'd0, 0, 1);
    go(1, 2'b00, 0, 32'h000c, 0, 0, 5'd0, 0, 0);
    // R6/R7 return with request already low
    go(1, 2'b11, 0, 32'h0010, 0, 0, 5'd0, 0, 0);
    #1 chk("R7", "iack after rfe, irq low", {31'b0, iack}, 32'h0);
    rd(5'd12, 32'h0000_00a3, "R6");

    // R5 entry on jump, then return with request still high
    go(1, 2'b01, 0, 32'h002c, 32'h3000, 0, 5'd0, 0, 1);
    rd(5'd14, 32'h3000, "R5");
    go(1, 2'b11, 0, 32'h0010, 0, 0, 5'd0, 0, 1);
    go(0, 0, 0, 0, 0, 0, 5'd0, 0, 1);
    go(1, 2'b00, 0, 32'h3004, 0, 0, 5'd0, 0, 1);
    #1 chk("R7", "iack held while irq high", {31'b0, iack}, 32'h1);
    go(0, 0, 0, 0, 0, 0, 5'd0, 0, 0);
    #1 chk("R7", "iack released after irq low", {31'b0, iack}, 32'h0);

    // R5 not-taken branch saves PC+4
    go(1, 2'b10, 0, 32'h0044, 32'h0080, 0, 5'd0, 0, 1);
    rd(5'd14, 32'h0044, "R5");
    go(0, 0, 0, 0, 0, 0, 5'd0, 0, 0);
    go(1, 2'b11, 0, 32'h0010, 0, 0, 5'd0, 0, 0);

    // R5/R8 taken branch with a colliding write
    go(1, 2'b10, 1, 32'h0054, 32'h0090, 1, 5'd13, 32'h0000_0055, 1);
    rd(5'd13, 32'h0, "R8");
    rd(5'd14, 32'h0090, "R5");
    go(0, 0, 0, 0, 0, 0, 5'd0, 0, 0);
    // R8 write colliding with rfe is dropped
    go(1, 2'b11, 0, 32'h0010, 0, 1, 5'd12, 32'h0000_ffff, 0);
    rd(5'd12, 32'h0000_00a3, "R8");
    repeat (3) go(0, 0, 0, 0, 0, 0, 5'd0, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule